// File: doc/BRIEF.md
# Error-Corrected Two-Port Word Memory

This block is a synchronous memory of 1024 words with a write port and a read port, each on its own clock. A 16-bit value written through the write port is stored together with six check bits in a 22-bit word. The read port checks the stored word, corrects any single flipped bit, flags double flips, and returns 16 bits of data with three status flags. A run-time mode pin switches the protection off so the block behaves as a plain 16-bit store.

The storage is a register array organised as 256 rows of 4 columns. The upper eight address bits pick the row and the lower two pick the column. The read result sits in an output register. That register changes only when an enabled read completes. It keeps its value through writes, disabled reads and idle clocks.

Top module: `ecc_sram_top`

## Requirements
- R1: On a rising edge of `wrClk` with `wrEnN` low, `wrAddr` and `wrData` are captured and the word is stored. When `wrEnN` is high the array keeps its contents.
- R2: On a rising edge of `rdClk` with `rdEnN` low, `rdAddr` is captured. `rdData` and the flags change at the next rising `rdClk` edge and not at the capture edge.
- R3: A rising `rdClk` edge with `rdEnN` high changes neither `rdData` nor the flags.
- R4: Writes never change `rdData` or the flags. The outputs keep the result of the last completed read.
- R5: Address bits 9:2 select one of 256 rows and bits 1:0 select one of 4 columns. All 1024 addresses hold independent words.
- R6: With `eccOff` = 0 on both the write and the read, a word that is read back without corruption returns the written data with all three flags low.
- R7: The stored word is laid out as follows. Bits 15:0 hold the data. Bits 20:16 hold Hamming checks c0..c4. Bit 21 holds the parity of all other 21 bits. Data bit i sits at code position p(i), the i-th integer of 3..21 that is not a power of two, so p(0)=3, p(1)=5, p(3)=7, p(8)=13 and p(15)=21. Check ck is the XOR of the data bits whose p has bit k set. An ECC read of a word with exactly one flipped data bit returns the corrected data with `errSingle`=1 and `errCheck`=0.
- R8: An ECC read of a word with exactly one flipped bit in 21:16 returns bits 15:0 unchanged with `errSingle`=1 and `errCheck`=1.
- R9: An ECC read of a word with two flipped bits returns bits 15:0 uncorrected with `errDouble`=1 and `errSingle`=`errCheck`=0.
- R10: With `eccOff` = 1 a write stores zeros in bits 21:16. A read in that mode returns bits 15:0 unchanged with all flags low.
- R11: If a read and a write target the same address on coincident clock edges, the read returns the contents from before the write.
- R12: While `rstN` is low, `rdData` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write port clock |
| rdClk | input | 1 | Read port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccOff | input | 1 | 1 selects plain storage without protection |
| wrEnN | input | 1 | Write enable, active low |
| wrAddr | input | 10 | Write address (row 9:2, column 1:0) |
| wrData | input | 16 | Write data |
| rdEnN | input | 1 | Read enable, active low |
| rdAddr | input | 10 | Read address (row 9:2, column 1:0) |
| rdData | output | 16 | Read data, corrected when protection is on |
| errSingle | output | 1 | A single flipped bit was found and corrected |
| errDouble | output | 1 | Two flipped bits were found, data not corrected |
| errCheck | output | 1 | The corrected single flip lay in the check field |

## Verification
A write is visible to a read whose capture edge comes at least one write edge later. A read result is due exactly one `rdClk` edge after its capture edge. The monitor looks at the outputs 1 ns after the capture edge and expects them to be unchanged. It then compares them 1 ns after the following edge against the value the driver queued. Hold behaviour is checked several idle and write cycles after a read completes. Corrupted words are built through the port by writing a chosen pattern with protection off, which leaves the check field at zero, and then reading it back with protection on.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W   = 16;
  localparam int HAM_W    = 5;
  localparam int CHK_W    = HAM_W + 1;
  localparam int WORD_W   = DATA_W + CHK_W;
  localparam int CODE_LEN = DATA_W + HAM_W;
  localparam int ADDR_W   = 10;
  localparam int COL_W    = 2;
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int DIDX_W   = $clog2(DATA_W);

  typedef struct packed {
    logic wrFire;
    logic wrBypass;
    logic rdFire;
    logic outLoad;
    logic outBypass;
  } memStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              dbl;
    logic              chk;
  } decRes_t;

  function automatic logic [HAM_W-1:0] hamChecks(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int idx;
    c = '0;
    idx = 0;
    for (int pos = 1; pos <= CODE_LEN; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[idx[DIDX_W-1:0]]) c = c ^ pos[HAM_W-1:0];
        idx = idx + 1;
      end
    end
    return c;
  endfunction

  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    c = hamChecks(d);
    return {(^d) ^ (^c), c};
  endfunction

  function automatic decRes_t eccDecode(input logic [WORD_W-1:0] w);
    decRes_t          r;
    logic [HAM_W-1:0] syn;
    logic             par;
    int               idx;
    r.data   = w[DATA_W-1:0];
    r.single = 1'b0;
    r.dbl    = 1'b0;
    r.chk    = 1'b0;
    syn = hamChecks(w[DATA_W-1:0]) ^ w[DATA_W+HAM_W-1:DATA_W];
    par = ^w;
    if (par) begin
      if ((syn & (syn - 1'b1)) == '0) begin
        r.single = 1'b1;
        r.chk    = 1'b1;
      end else if (int'(syn) <= CODE_LEN) begin
        r.single = 1'b1;
        idx = 0;
        for (int pos = 1; pos <= CODE_LEN; pos++) begin
          if ((pos & (pos - 1)) != 0) begin
            if (pos == int'(syn)) r.data[idx[DIDX_W-1:0]] = ~r.data[idx[DIDX_W-1:0]];
            idx = idx + 1;
          end
        end
      end else begin
        r.dbl = 1'b1;
      end
    end else if (syn != '0) begin
      r.dbl = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
(
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       eccOff,
  input  logic       wrEnN,
  input  logic       rdEnN,
  output memStrobe_t strobe
);
  logic rdValidQ;
  logic rdBypassQ;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ  <= 1'b0;
      rdBypassQ <= 1'b0;
    end else begin
      rdValidQ  <= !rdEnN;
      rdBypassQ <= eccOff;
    end
  end

  always_comb begin
    strobe.wrFire    = rstN && !wrEnN;
    strobe.wrBypass  = eccOff;
    strobe.rdFire    = !rdEnN;
    strobe.outLoad   = rdValidQ;
    strobe.outBypass = rdBypassQ;
  end

  // R2: an enabled read always schedules an output load on the next edge
  assert_load_follows_enable_R2: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdEnN |=> strobe.outLoad);
endmodule

// File: rtl/ecc_sram_datapath.sv
module ecc_sram_datapath
  import ecc_sram_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              errSingle,
  output logic              errDouble,
  output logic              errCheck
);
  logic [WORD_W-1:0] memArray [ROWS][COLS];
  logic [WORD_W-1:0] wrWord;
  logic [WORD_W-1:0] rdWordQ;
  decRes_t           decoded;

  logic [ROW_W-1:0] wrRow, rdRow;
  logic [COL_W-1:0] wrCol, rdCol;
  assign wrRow = wrAddr[ADDR_W-1:COL_W];
  assign wrCol = wrAddr[COL_W-1:0];
  assign rdRow = rdAddr[ADDR_W-1:COL_W];
  assign rdCol = rdAddr[COL_W-1:0];

  always_comb begin
    wrWord = {strobe.wrBypass ? {CHK_W{1'b0}} : eccEncode(wrData), wrData};
  end

  always_ff @(posedge wrClk) begin
    if (strobe.wrFire) memArray[wrRow][wrCol] <= wrWord;
  end

  // capture stage: array sampled at the read edge, so a same-edge write is not seen
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdWordQ <= '0;
    else if (strobe.rdFire) rdWordQ <= memArray[rdRow][rdCol];
  end

  always_comb decoded = eccDecode(rdWordQ);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      errSingle <= 1'b0;
      errDouble <= 1'b0;
      errCheck  <= 1'b0;
    end else if (strobe.outLoad) begin
      if (strobe.outBypass) begin
        rdData    <= rdWordQ[DATA_W-1:0];
        errSingle <= 1'b0;
        errDouble <= 1'b0;
        errCheck  <= 1'b0;
      end else begin
        rdData    <= decoded.data;
        errSingle <= decoded.single;
        errDouble <= decoded.dbl;
        errCheck  <= decoded.chk;
      end
    end
  end

  // R3: no load strobe, no change at the outputs
  assert_hold_when_idle_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobe.outLoad |=> ($stable(rdData) && $stable({errSingle, errDouble, errCheck})));

  // R10: a bypass load leaves every flag low
  assert_bypass_quiet_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    (strobe.outLoad && strobe.outBypass) |=> (!errSingle && !errDouble && !errCheck));

  // R8: a check-field flip is always reported as a corrected single flip
  assert_check_is_single_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    errCheck |-> errSingle);

  // R9: a double flip is never also reported as single
  assert_double_exclusive_R9: assert property (@(posedge rdClk) disable iff (!rstN)
    errDouble |-> !errSingle);
endmodule

// File: rtl/ecc_sram_top.sv
module ecc_sram_top
  import ecc_sram_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              eccOff,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              errSingle,
  output logic              errDouble,
  output logic              errCheck
);
  memStrobe_t strobe;

  ecc_sram_ctrl u_ctrl (
    .rdClk (rdClk),
    .rstN  (rstN),
    .eccOff(eccOff),
    .wrEnN (wrEnN),
    .rdEnN (rdEnN),
    .strobe(strobe)
  );

  ecc_sram_datapath u_dp (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .errSingle(errSingle),
    .errDouble(errDouble),
    .errCheck (errCheck)
  );
endmodule

// File: tb/ecc_sram_top_tb.sv
module ecc_sram_top_tb;
  logic        wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0, eccOff = 1'b0;
  logic        wrEnN = 1'b1, rdEnN = 1'b1;
  logic [9:0]  wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        errSingle, errDouble, errCheck;

  int checks = 0;
  int fails  = 0;
  logic [18:0] expQ[$];
  string       tagQ[$];
  logic [18:0] lastOut = '0;

  always #2 begin
    wrClk = ~wrClk;
    rdClk = ~rdClk;
  end

  ecc_sram_top u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .eccOff(eccOff),
    .wrEnN(wrEnN), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnN(rdEnN), .rdAddr(rdAddr), .rdData(rdData),
    .errSingle(errSingle), .errDouble(errDouble), .errCheck(errCheck)
  );

  function automatic logic [18:0] outNow();
    return {errSingle, errDouble, errCheck, rdData};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual flags/data %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [15:0] d, input logic off);
    @(negedge wrClk);
    eccOff = off; wrEnN = 1'b0; wrAddr = a; wrData = d;
    @(negedge wrClk);
    wrEnN = 1'b1;
  endtask

  // flags field: {single, double, check}
  task automatic doRead(input logic [9:0] a, input logic off, input logic [15:0] d,
                        input logic [2:0] f, input string tag);
    @(negedge rdClk);
    eccOff = off; rdEnN = 1'b0; rdAddr = a;
    expQ.push_back({f, d}); tagQ.push_back(tag);
    @(negedge rdClk);
    rdEnN = 1'b1;
    @(negedge rdClk);
  endtask

  // monitor: unchanged at capture edge, result one edge later
  initial begin
    forever begin
      @(posedge rdClk);
      if (rstN && !rdEnN) begin
        #1 check(outNow() == lastOut, "R2 early change", outNow(), lastOut);
        @(posedge rdClk);
        #1;
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", outNow(), '0);
        end else begin
          logic [18:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outNow() == e, t, outNow(), e);
        end
        lastOut = outNow();
      end
    end
  end

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge rdClk);
    check(outNow() == '0, "R12 reset state", outNow(), '0);
    rstN = 1'b1;

    // R1 R5 R6: clean writes and reads, column and row neighbours
    doWrite(10'h000, 16'h1234, 1'b0);
    doWrite(10'h001, 16'hABCD, 1'b0);
    doWrite(10'h004, 16'h5A5A, 1'b0);
    doWrite(10'h3FF, 16'hFFFF, 1'b0);
    doRead(10'h000, 1'b0, 16'h1234, 3'b000, "R6 clean addr 000");
    doRead(10'h001, 1'b0, 16'hABCD, 3'b000, "R5 column neighbour");
    doRead(10'h004, 1'b0, 16'h5A5A, 3'b000, "R5 row neighbour");
    doRead(10'h3FF, 1'b0, 16'hFFFF, 3'b000, "R6 top address");

    // R1: disabled write leaves the word
    @(negedge wrClk);
    wrEnN = 1'b1; wrAddr = 10'h000; wrData = 16'h9999;
    @(negedge wrClk);
    doRead(10'h000, 1'b0, 16'h1234, 3'b000, "R1 disabled write ignored");

    // R3 R4: idle reads and writes do not disturb the output
    doWrite(10'h000, 16'h7777, 1'b0);
    @(negedge rdClk); rdAddr = 10'h004;
    repeat (3) @(negedge rdClk);
    check(outNow() == {3'b000, 16'h1234}, "R4 R3 output held", outNow(), {3'b000, 16'h1234});
    doRead(10'h000, 1'b0, 16'h7777, 3'b000, "R1 enabled write stored");

    // R10: bypass reads and writes
    doRead(10'h001, 1'b1, 16'hABCD, 3'b000, "R10 bypass read of protected word");
    doWrite(10'h010, 16'h0007, 1'b1);
    doRead(10'h010, 1'b1, 16'h0007, 3'b000, "R10 bypass round trip");

    // R8: check field zero makes overall parity (or c0) the lone flip
    doRead(10'h010, 1'b0, 16'h0007, 3'b101, "R8 R10 parity bit flip");
    doWrite(10'h011, 16'h000B, 1'b1);
    doRead(10'h011, 1'b0, 16'h000B, 3'b101, "R8 hamming check flip");

    // R7: one data bit flipped against the all-zero code word
    doWrite(10'h012, 16'h0100, 1'b1);
    doRead(10'h012, 1'b0, 16'h0000, 3'b100, "R7 data bit 8");
    doWrite(10'h013, 16'h8000, 1'b1);
    doRead(10'h013, 1'b0, 16'h0000, 3'b100, "R7 data bit 15");
    doWrite(10'h014, 16'h0001, 1'b1);
    doRead(10'h014, 1'b0, 16'h0000, 3'b100, "R7 data bit 0");

    // R9: two data bits flipped
    doWrite(10'h015, 16'h0003, 1'b1);
    doRead(10'h015, 1'b0, 16'h0003, 3'b010, "R9 bits 0 and 1");
    doWrite(10'h016, 16'h8001, 1'b1);
    doRead(10'h016, 1'b0, 16'h8001, 3'b010, "R9 bits 0 and 15");

    // R11: coincident read and write to one address
    doWrite(10'h020, 16'h1111, 1'b0);
    @(negedge rdClk);
    eccOff = 1'b0;
    wrEnN = 1'b0; wrAddr = 10'h020; wrData = 16'h2222;
    rdEnN = 1'b0; rdAddr = 10'h020;
    expQ.push_back({3'b000, 16'h1111}); tagQ.push_back("R11 old contents on collision");
    @(negedge rdClk);
    wrEnN = 1'b1; rdEnN = 1'b1;
    @(negedge rdClk);
    doRead(10'h020, 1'b0, 16'h2222, 3'b000, "R11 new contents afterwards");

    repeat (4) @(negedge rdClk);
    check(expQ.size() == 0, "R2 results outstanding", 19'(expQ.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule